// File: doc/BRIEF.md
# Serial ADC control-word sequencer

This block is the digital front end of an eight-input serial analog-to-digital converter. A host lowers an active-low select, then clocks an eight-bit control word in most-significant-bit first on a serial data line. The block hunts for the start bit and counts the control bits. It opens the track/hold switch partway through the word and closes it again once the last bit has arrived. When the word is complete it latches the configuration. That configuration steers the positive and negative multiplexer selects and decides how conversion results are coded.

A signed eleven-bit difference sample, in steps of one thousand twenty-fourth of the reference, is presented to the block. It is turned into a ten-bit output code: plain binary in unipolar operation, two's complement in bipolar operation. The code saturates at the edge of the chosen range, and a flag reports when that happens. A completion pulse from the converter reopens the track switch.

The serial inputs are treated as synchronous to the block clock and slower than it. Each serial edge is detected one register stage after sampling.

Top module: `adc_ctl_seq`

## Requirements
- R1: After select falls, zero bits are discarded. The first 1 sampled on a rising serial edge is the start bit and counts as control bit one. The word is {start, sel[2:0], uni, sgl, pd[1:0]} with the start bit first.
- R2: `track` goes high on the falling serial edge that follows control bit five. It stays low before that edge unless it was already reopened.
- R3: `track` goes low on the falling serial edge that follows control bit eight, and the configuration is latched on that edge.
- R4: Select high clears the bit count, drives `track` low and discards a partial word. The latched configuration is unchanged, and the next word is received from its start bit.
- R5: With sgl=1 (single-ended), `mux_pos` = {sel[1], sel[0], sel[2]} (sel 000,100,001,101,010,110,011,111 give inputs 0..7), `neg_gnd`=1 and `mux_neg`=0.
- R6: With sgl=0 (differential), `mux_pos` is as in R5, `mux_neg` = `mux_pos` with bit 0 inverted, and `neg_gnd`=0.
- R7: Single-ended operation always codes results as unipolar, whatever the uni bit says.
- R8: Unipolar coding (uni=1 or sgl=1): `code` is the sample clamped to 0..1023 in plain binary. A negative sample gives 0 with `clamp`=1. The result is due one clock after the sample.
- R9: Bipolar coding (uni=0, sgl=0): `code` is the sample clamped to -512..511 in ten-bit two's complement, and `clamp`=1 when limited. The result is due one clock after the sample.
- R10: A `conv_done` pulse, while select is low and no word is in progress, drives `track` high.
- R11: The two power-down bits are stored with the word but have no effect on `track`, the multiplexer selects or the code.
- R12: After reset: `track`=0, `mux_pos`=0, `neg_gnd`=1, `mux_neg`=0, `code`=0, `clamp`=0, and the configuration is single-ended unipolar.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial control data, MSB first |
| conv_done | input | 1 | One-clock pulse marking the end of a conversion |
| sample_in | input | 11 | Signed difference sample in LSBs of Vref/1024 |
| track | output | 1 | 1 = track, 0 = hold |
| mux_pos | output | 3 | Positive input select |
| mux_neg | output | 3 | Negative input select (differential) |
| neg_gnd | output | 1 | Negative input tied to analog ground |
| code | output | 10 | Formatted conversion code |
| clamp | output | 1 | Code was saturated |

## Verification
A serial edge reaches `track` and the latched configuration two block clocks after the pin changes: one clock for the sampling stage and one for the edge-detect register. The bench holds each serial level for three clocks and reads the outputs only at the end of that phase. The code and clamp results are registered once, so the bench drives a sample on a falling clock edge and compares one full clock later. The select pin passes through the same sampling stage as the serial clock, so after an abort the bench waits several clocks before reading `track` and the multiplexer selects.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W = 3;

    // Latched configuration taken from a complete control word
    typedef struct packed {
        logic [CH_W-1:0] sel;
        logic            uni;
        logic            sgl;
        logic [1:0]      pd;
    } ctl_cfg_t;

    localparam ctl_cfg_t CFG_RESET = '{sel: '0, uni: 1'b1, sgl: 1'b1, pd: 2'b00};

    // Select code to input number: the code is rotated, not binary
    function automatic logic [CH_W-1:0] sel_to_chan(input logic [CH_W-1:0] s);
        return {s[1], s[0], s[2]};
    endfunction

endpackage

// File: rtl/adc_shift_ctl.sv
module adc_shift_ctl #(
    parameter int WORD_W   = 8,
    parameter int TRACK_AT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              conv_done,
    output logic              track,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_TRK  = CNT_W'(TRACK_AT);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic              sclk_s;
        logic              sclk_p;
        logic              cs_s;
        logic              din_s;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              trk;
        logic              vld;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d        = st_q;
        st_d.sclk_s = sclk;
        st_d.sclk_p = st_q.sclk_s;
        st_d.cs_s   = cs_n;
        st_d.din_s  = din;
        st_d.vld    = 1'b0;
        rise = st_q.sclk_s & ~st_q.sclk_p;
        fall = ~st_q.sclk_s & st_q.sclk_p;
        if (st_q.cs_s) begin
            st_d.cnt = '0;
            st_d.trk = 1'b0;
        end else if (rise) begin
            if (st_q.cnt == '0) begin
                if (st_q.din_s) begin
                    st_d.sh  = {{(WORD_W-1){1'b0}}, 1'b1};
                    st_d.cnt = CNT_ONE;
                end
            end else if (st_q.cnt < CNT_FULL) begin
                st_d.sh  = {st_q.sh[WORD_W-2:0], st_q.din_s};
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end else if (fall) begin
            if (st_q.cnt == CNT_TRK) begin
                st_d.trk = 1'b1;
            end else if (st_q.cnt == CNT_FULL) begin
                st_d.trk = 1'b0;
                st_d.vld = 1'b1;
                st_d.cnt = '0;
            end
        end else if (conv_done && st_q.cnt == '0) begin
            st_d.trk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_s <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign track    = st_q.trk;
    assign word_vld = st_q.vld;
    assign word     = st_q.sh;

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);
    assert_track_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.trk) |-> ($past(st_q.cnt) == CNT_TRK || $past(conv_done)));
    assert_track_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.trk) |-> ($past(st_q.cnt) == CNT_FULL || $past(st_q.cs_s)));
    assert_hold_on_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cs_s |=> (!st_q.trk && st_q.cnt == '0));
endmodule

// File: rtl/adc_mux_dec.sv
module adc_mux_dec
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_vld,
    input  logic [7:0]      word,
    output logic [CH_W-1:0] mux_pos,
    output logic [CH_W-1:0] mux_neg,
    output logic            neg_gnd,
    output logic            uni_eff
);
    ctl_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (word_vld) begin
            cfg_d.sel = word[6:4];
            cfg_d.uni = word[3];
            cfg_d.sgl = word[2];
            cfg_d.pd  = word[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        mux_pos = sel_to_chan(cfg_q.sel);
        neg_gnd = cfg_q.sgl;
        mux_neg = cfg_q.sgl ? '0 : (mux_pos ^ CH_W'(1));
        uni_eff = cfg_q.uni | cfg_q.sgl;
    end

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(cfg_q));
    assert_diff_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_gnd |-> (mux_neg[CH_W-1:1] == mux_pos[CH_W-1:1] && mux_neg[0] != mux_pos[0]));
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
    parameter int SAMPLE_W = 11,
    parameter int CODE_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       uni,
    output logic        [CODE_W-1:0]   code,
    output logic                       clamp
);
    localparam int UMAX = (1 << CODE_W) - 1;
    localparam int BMAX = (1 << (CODE_W - 1)) - 1;
    localparam int BMIN = -(1 << (CODE_W - 1));

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              clamp;
    } out_t;

    out_t o_d, o_q;
    int   sv, lo, hi;

    always_comb begin
        sv = int'(sample);
        lo = uni ? 0 : BMIN;
        hi = uni ? UMAX : BMAX;
        o_d.clamp = 1'b0;
        if (sv < lo) begin
            o_d.code  = CODE_W'(lo);
            o_d.clamp = 1'b1;
        end else if (sv > hi) begin
            o_d.code  = CODE_W'(hi);
            o_d.clamp = 1'b1;
        end else begin
            o_d.code = CODE_W'(sv);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign code  = o_q.code;
    assign clamp = o_q.clamp;

    assert_uni_negative_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uni && sample[SAMPLE_W-1]) |=> (o_q.code == '0 && o_q.clamp));
    assert_bip_top_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!uni && int'(sample) > BMAX) |=> (o_q.code == CODE_W'(BMAX) && o_q.clamp));
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq #(
    parameter int TRACK_AT = 5,
    parameter int SAMPLE_W = 11,
    parameter int CODE_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                din,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                track,
    output logic [2:0]          mux_pos,
    output logic [2:0]          mux_neg,
    output logic                neg_gnd,
    output logic [CODE_W-1:0]   code,
    output logic                clamp
);
    localparam int WORD_W = 8;

    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              uni_eff;

    adc_shift_ctl #(.WORD_W(WORD_W), .TRACK_AT(TRACK_AT)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .conv_done(conv_done), .track(track), .word_vld(word_vld), .word(word)
    );

    adc_mux_dec u_dec (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_gnd(neg_gnd), .uni_eff(uni_eff)
    );

    adc_code_fmt #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .sample($signed(sample_in)), .uni(uni_eff),
        .code(code), .clamp(clamp)
    );
endmodule

// File: tb/adc_ctl_seq_tb.sv
module adc_ctl_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        conv_done = 1'b0;
    logic [10:0] sample_in = '0;
    logic        track, neg_gnd, clamp;
    logic [2:0]  mux_pos, mux_neg;
    logic [9:0]  code;

    int n_vec = 0;
    int n_bad = 0;
    bit trk_pre = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_ctl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .conv_done(conv_done), .sample_in(sample_in), .track(track),
        .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_gnd(neg_gnd),
        .code(code), .clamp(clamp)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] exp_chan(input logic [2:0] s);
        return {s[1], s[0], s[2]};
    endfunction

    // returns {clamp, code}
    function automatic logic [10:0] exp_code(input logic [10:0] s, input bit uni);
        int v;
        v = int'($signed(s));
        if (uni) begin
            if (v < 0) return {1'b1, 10'd0};
            return {1'b0, 10'(v)};
        end
        if (v > 511)  return {1'b1, 10'd511};
        if (v < -512) return {1'b1, 10'h200};
        return {1'b0, 10'(v)};
    endfunction

    task automatic send_bit(input logic b);
        din = b;
        clks(1);
        sclk = 1'b1;
        clks(3);
        sclk = 1'b0;
        clks(3);
    endtask

    task automatic send_word(input logic [2:0] sel, input bit uni, input bit sgl,
                             input logic [1:0] pd, input int zeros);
        logic [7:0] w;
        w = {1'b1, sel, uni, sgl, pd};
        for (int i = 0; i < zeros; i++) send_bit(1'b0);
        for (int i = 7; i >= 0; i--) begin
            send_bit(w[i]);
            if (i == 4)      chk("R2 track still held after bit 4", int'(track), int'(trk_pre));
            else if (i == 3) chk("R2 track after bit 5", int'(track), 1);
            else if (i == 1) chk("R2 track kept through bit 7", int'(track), 1);
            else if (i == 0) chk("R3 hold after bit 8", int'(track), 0);
        end
        trk_pre = 1'b0;
        chk("R1 R5 positive select", int'(mux_pos), int'(exp_chan(sel)));
        if (sgl) begin
            chk("R5 negative to ground", int'(neg_gnd), 1);
            chk("R5 negative select idle", int'(mux_neg), 0);
        end else begin
            chk("R6 negative not grounded", int'(neg_gnd), 0);
            chk("R6 negative pair", int'(mux_neg), int'(exp_chan(sel) ^ 3'd1));
        end
    endtask

    task automatic try_code(input logic [10:0] s, input bit uni, input string req);
        logic [10:0] e;
        sample_in = s;
        clks(1);
        e = exp_code(s, uni);
        chk(req, int'(code), int'(e[9:0]));
        chk(req, int'(clamp), int'(e[10]));
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        clks(3);
        rst_n = 1'b1;
        clks(2);
        // R12 reset state
        chk("R12 track", int'(track), 0);
        chk("R12 mux_pos", int'(mux_pos), 0);
        chk("R12 neg_gnd", int'(neg_gnd), 1);
        chk("R12 mux_neg", int'(mux_neg), 0);
        chk("R12 code", int'(code), 0);
        chk("R12 clamp", int'(clamp), 0);
        cs_n = 1'b0;
        clks(3);

        // R1 leading zeros, R5 single-ended
        send_word(3'b101, 1'b1, 1'b1, 2'b11, 2);
        // R7 single-ended with uni=0 still unipolar
        send_word(3'b011, 1'b0, 1'b1, 2'b00, 0);
        try_code(11'h7FF, 1'b1, "R7 single-ended forces unipolar");
        try_code(11'd700, 1'b1, "R7 single-ended above bipolar range");
        // R6 differential bipolar and R9 corners
        send_word(3'b110, 1'b0, 1'b0, 2'b01, 1);
        try_code(11'd511, 1'b0, "R9 bipolar top");
        try_code(11'd512, 1'b0, "R9 bipolar above top");
        try_code(11'h600, 1'b0, "R9 bipolar minus 512");
        try_code(11'h5FF, 1'b0, "R9 bipolar below bottom");
        try_code(11'h400, 1'b0, "R9 bipolar most negative");
        // R8 differential unipolar corners
        send_word(3'b000, 1'b1, 1'b0, 2'b10, 0);
        try_code(11'h7FF, 1'b1, "R8 negative gives zero");
        try_code(11'd1023, 1'b1, "R8 full scale");
        try_code(11'd0, 1'b1, "R8 zero");

        // R11 power-down bits make no difference
        send_word(3'b010, 1'b1, 1'b0, 2'b00, 0);
        send_word(3'b010, 1'b1, 1'b0, 2'b11, 0);
        chk("R11 pd bits ignored for select", int'(mux_pos), int'(exp_chan(3'b010)));
        try_code(11'h7F0, 1'b1, "R11 pd bits ignored for code");

        // R4 abort mid-word
        for (int i = 7; i >= 2; i--) send_bit(i == 7 ? 1'b1 : 1'b0);
        chk("R4 track open before abort", int'(track), 1);
        cs_n = 1'b1;
        clks(4);
        chk("R4 hold after abort", int'(track), 0);
        chk("R4 config kept after abort", int'(mux_pos), int'(exp_chan(3'b010)));
        chk("R4 config kept after abort", int'(neg_gnd), 0);
        cs_n = 1'b0;
        clks(3);
        send_word(3'b111, 1'b0, 1'b0, 2'b00, 0);

        // R10 conversion done reopens track
        conv_done = 1'b1;
        clks(1);
        conv_done = 1'b0;
        clks(2);
        chk("R10 track after conv_done", int'(track), 1);
        trk_pre = 1'b1;
        send_word(3'b001, 1'b1, 1'b1, 2'b00, 1);

        // random words and samples
        for (int n = 0; n < 40; n++) begin
            logic [2:0] sel;
            bit uni, sgl;
            sel = 3'($urandom);
            uni = 1'($urandom);
            sgl = 1'($urandom);
            send_word(sel, uni, sgl, 2'($urandom), int'($urandom % 4));
            for (int k = 0; k < 8; k++)
                try_code(11'($urandom), uni | sgl, (uni | sgl) ? "R8 random unipolar" : "R9 random bipolar");
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule